// File: doc/BRIEF.md
# Split Program Memory Fetch Selector

This block produces instruction fetch addresses for a byte-oriented processor core and routes each fetch either to a small on-chip code ROM or to an external program memory port. It keeps a 16-bit program counter. The counter clears on reset, steps by one for every byte delivered, and can be reloaded for jumps and calls. Each delivered byte comes with a flag that names the memory which supplied it.

The choice of memory depends on a strap input and on the address. With the strap high, the lowest 4 KB of the code space is read from the internal ROM, and every address above that region goes to the external port. With the strap low, the internal ROM is never used and every address goes to the external port. External fetches use a request/valid handshake, and the counter does not move while an external byte is still outstanding. The internal ROM holds a fixed image that is computed from the address.

Top module: `fetch_selector`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `pc` is 0000h and `byte_valid` and `ext_req` are low.
- R2: In the idle state with `fetch_req` high, `load_en` low, `low_rom_en` high and `pc` below 1000h, the next cycle shows `byte_valid` high and `byte_ext` low. `byte_data` holds the internal image for that address: addresses 000h, 001h and 002h hold 02h, 10h and 00h, and every other address A holds A[7:0] XOR A[11:4] XOR C3h.
- R3: Each delivered byte moves `pc` up by exactly one, and FFFFh wraps to 0000h. Across an N-byte instruction, `pc` therefore advances by N.
- R4: With `low_rom_en` high, a fetch request at an address of 1000h or above raises `ext_req` in the next cycle, and `ext_addr` equals `pc`.
- R5: With `low_rom_en` low, every fetch request raises `ext_req`, and none is served internally.
- R6: While `ext_req` is high, `pc` and `ext_addr` stay unchanged until `ext_valid` is seen. In the cycle after `ext_valid`, `byte_valid` is high, `byte_ext` is high, `byte_data` equals the `ext_data` that was sampled, and `ext_req` is low. `ext_req` and `byte_valid` are never high together.
- R7: In the idle state, `load_en` writes `load_addr` into `pc` in the next cycle. It takes priority over `fetch_req` in the same cycle, so no byte is fetched in that cycle.
- R8: `load_en` and `fetch_req` have no effect while `ext_req` is high. `ext_valid` has no effect while `ext_req` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_rom_en | input | 1 | Strap: when high, the low 4 KB is served by the internal ROM |
| fetch_req | input | 1 | Request the byte at `pc` |
| load_en | input | 1 | Load `load_addr` into the program counter |
| load_addr | input | PC_W (16) | Jump or call target |
| ext_req | output | 1 | External fetch outstanding |
| ext_addr | output | PC_W (16) | Address of the external fetch |
| ext_valid | input | 1 | External memory returns a byte |
| ext_data | input | DATA_W (8) | Byte returned by external memory |
| pc | output | PC_W (16) | Current program counter |
| byte_valid | output | 1 | One-cycle strobe: fetched byte available |
| byte_data | output | DATA_W (8) | Fetched byte |
| byte_ext | output | 1 | High when the byte came from external memory |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, a 12-bit internal ROM address and 8-bit data. At these values the internal/external boundary at 0FFFh/1000h and the wrap from FFFFh to 0000h can each be reached in a single load, so both edges are exercised directly. The same sizes keep the computed ROM image small enough for the reference model to evaluate on every internal fetch. Random phases then mix loads, strap changes and external latencies from zero to several cycles.

// File: rtl/fsel_pkg.sv
`timescale 1ns/1ps
package fsel_pkg;
    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_WAIT = 1'b1
    } fs_state_e;

    localparam int unsigned FSEL_PC_W   = 16;
    localparam int unsigned FSEL_ROM_AW = 12;
    localparam int unsigned FSEL_DATA_W = 8;
endpackage

// File: rtl/fsel_region.sv
`timescale 1ns/1ps
module fsel_region #(
    parameter int unsigned PC_W   = 16,
    parameter int unsigned ROM_AW = 12
) (
    input  logic [PC_W-1:0] addr,
    input  logic            low_rom_en,
    output logic            internal
);
    generate
        if (ROM_AW >= PC_W) begin : g_full
            // ROM covers the whole space: only the strap decides
            assign internal = low_rom_en;
        end else begin : g_split
            assign internal = low_rom_en && (addr[PC_W-1:ROM_AW] == '0);
        end
    endgenerate
endmodule

// File: rtl/fsel_rom.sv
`timescale 1ns/1ps
module fsel_rom #(
    parameter int unsigned ROM_AW = 12,
    parameter int unsigned DATA_W = 8
) (
    input  logic [ROM_AW-1:0] addr,
    output logic [DATA_W-1:0] data
);
    always_comb begin
        case (addr)
            ROM_AW'(0): data = DATA_W'(8'h02);
            ROM_AW'(1): data = DATA_W'(8'h10);
            ROM_AW'(2): data = DATA_W'(8'h00);
            default:    data = DATA_W'(addr) ^ DATA_W'(addr >> 4) ^ DATA_W'(8'hC3);
        endcase
    end
endmodule

// File: rtl/fetch_selector.sv
`timescale 1ns/1ps
module fetch_selector
    import fsel_pkg::*;
#(
    parameter int unsigned PC_W   = FSEL_PC_W,
    parameter int unsigned ROM_AW = FSEL_ROM_AW,
    parameter int unsigned DATA_W = FSEL_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              low_rom_en,
    input  logic              fetch_req,
    input  logic              load_en,
    input  logic [PC_W-1:0]   load_addr,
    output logic              ext_req,
    output logic [PC_W-1:0]   ext_addr,
    input  logic              ext_valid,
    input  logic [DATA_W-1:0] ext_data,
    output logic [PC_W-1:0]   pc,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output logic              byte_ext
);
    localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);

    typedef struct packed {
        fs_state_e         st;
        logic [PC_W-1:0]   pc;
        logic              bv;
        logic [DATA_W-1:0] data;
        logic              ext;
    } fs_regs_t;

    fs_regs_t regs_d, regs_q;
    logic              is_int;
    logic [DATA_W-1:0] rom_byte;

    fsel_region #(.PC_W(PC_W), .ROM_AW(ROM_AW)) u_region (
        .addr       (regs_q.pc),
        .low_rom_en (low_rom_en),
        .internal   (is_int)
    );

    fsel_rom #(.ROM_AW(ROM_AW), .DATA_W(DATA_W)) u_rom (
        .addr (regs_q.pc[ROM_AW-1:0]),
        .data (rom_byte)
    );

    always_comb begin
        regs_d    = regs_q;
        regs_d.bv = 1'b0;
        case (regs_q.st)
            FS_IDLE: begin
                if (load_en) begin
                    regs_d.pc = load_addr;
                end else if (fetch_req) begin
                    if (is_int) begin
                        regs_d.bv   = 1'b1;
                        regs_d.data = rom_byte;
                        regs_d.ext  = 1'b0;
                        regs_d.pc   = regs_q.pc + PC_STEP;
                    end else begin
                        regs_d.st = FS_WAIT;
                    end
                end
            end
            FS_WAIT: begin
                if (ext_valid) begin
                    regs_d.bv   = 1'b1;
                    regs_d.data = ext_data;
                    regs_d.ext  = 1'b1;
                    regs_d.pc   = regs_q.pc + PC_STEP;
                    regs_d.st   = FS_IDLE;
                end
            end
            default: regs_d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign pc         = regs_q.pc;
    assign ext_addr   = regs_q.pc;
    assign ext_req    = (regs_q.st == FS_WAIT);
    assign byte_valid = regs_q.bv;
    assign byte_data  = regs_q.data;
    assign byte_ext   = regs_q.ext;

    // R6: counter frozen while an external byte is outstanding
    a_r6_hold_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_valid) |=> $stable(pc));

    // R6: request and delivery strobe are mutually exclusive
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ext_req, byte_valid}));

    // R3: every delivered byte advances the counter by one
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> (pc == PC_W'($past(pc) + PC_STEP)));

    // R2: internal deliveries only from the low region with strap high
    a_r2_int_region: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !byte_ext) |-> ($past(low_rom_en) && ($past(pc) >> ROM_AW) == '0));

    // R5: an external request never targets the internal region with strap high
    a_r5_ext_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_req) |-> (!$past(low_rom_en) || (ext_addr >> ROM_AW) != '0));
endmodule

// File: tb/test_fetch_selector.sv
`timescale 1ns/1ps
module test_fetch_selector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        low_rom_en = 1'b1;
    logic        fetch_req = 1'b0;
    logic        load_en = 1'b0;
    logic [15:0] load_addr = '0;
    logic        ext_req;
    logic [15:0] ext_addr;
    logic        ext_valid = 1'b0;
    logic [7:0]  ext_data = '0;
    logic [15:0] pc;
    logic        byte_valid;
    logic [7:0]  byte_data;
    logic        byte_ext;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    fetch_selector i_fetch_selector (
        .clk(clk), .rst_n(rst_n), .low_rom_en(low_rom_en), .fetch_req(fetch_req),
        .load_en(load_en), .load_addr(load_addr), .ext_req(ext_req), .ext_addr(ext_addr),
        .ext_valid(ext_valid), .ext_data(ext_data), .pc(pc), .byte_valid(byte_valid),
        .byte_data(byte_data), .byte_ext(byte_ext)
    );

    function automatic logic [7:0] rom_ref(input logic [15:0] a);
        if (a == 16'h0000) return 8'h02;
        if (a == 16'h0001) return 8'h10;
        if (a == 16'h0002) return 8'h00;
        return a[7:0] ^ a[11:4] ^ 8'hC3;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, advanced on each rising edge
    logic [15:0] m_pc = '0;
    bit          m_wait = 1'b0;
    bit          m_bv = 1'b0;
    logic [7:0]  m_data = '0;
    bit          m_ext = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pc = '0; m_wait = 0; m_bv = 0; m_data = '0; m_ext = 0;
        end else begin
            m_bv = 0;
            if (m_wait) begin
                if (ext_valid) begin
                    m_bv = 1; m_data = ext_data; m_ext = 1; m_pc = m_pc + 16'd1; m_wait = 0;
                end
            end else if (load_en) begin
                m_pc = load_addr;
            end else if (fetch_req) begin
                if (low_rom_en && m_pc < 16'h1000) begin
                    m_bv = 1; m_data = rom_ref(m_pc); m_ext = 0; m_pc = m_pc + 16'd1;
                end else begin
                    m_wait = 1;
                end
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(pc == m_pc, "R3 pc", pc, m_pc);
            check(ext_req == m_wait, "R4 ext_req", ext_req, m_wait);
            if (m_wait) check(ext_addr == m_pc, "R6 ext_addr", ext_addr, m_pc);
            check(byte_valid == m_bv, "R2 byte_valid", byte_valid, m_bv);
            if (m_bv) begin
                check(byte_ext == m_ext, "R5 byte_ext", byte_ext, m_ext);
                check(byte_data == m_data, m_ext ? "R6 byte_data" : "R2 byte_data", byte_data, m_data);
            end
        end
    end

    task automatic serve_ext(input int delay, input logic [7:0] d);
        while (!ext_req) @(negedge clk);
        repeat (delay) @(negedge clk);
        ext_valid = 1'b1; ext_data = d;
        @(negedge clk);
        ext_valid = 1'b0;
    endtask

    task automatic summary();
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(pc == 16'h0 && !ext_req && !byte_valid, "R1 reset state", {pc, 3'b0, ext_req, 3'b0, byte_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pc == 16'h0 && !ext_req && !byte_valid, "R1 after release", pc, 0);

        // R2: four internal bytes back to back
        fetch_req = 1'b1;
        repeat (4) @(negedge clk);
        fetch_req = 1'b0;
        check(pc == 16'h0004, "R3 four bytes", pc, 16'h0004);

        // R7: load wins over fetch in the same cycle
        load_en = 1'b1; load_addr = 16'h0FFE; fetch_req = 1'b1;
        @(negedge clk);
        load_en = 1'b0;
        check(pc == 16'h0FFE && !byte_valid, "R7 load priority", pc, 16'h0FFE);
        // 0FFE, 0FFF internal; 1000 external (R4 boundary)
        repeat (2) @(negedge clk);
        @(negedge clk);
        check(ext_req && ext_addr == 16'h1000, "R4 boundary request", ext_addr, 16'h1000);
        // R8: load and fetch ignored while waiting
        load_en = 1'b1; load_addr = 16'h1234;
        repeat (2) @(negedge clk);
        check(pc == 16'h1000, "R8 load ignored in wait", pc, 16'h1000);
        load_en = 1'b0; fetch_req = 1'b0;
        serve_ext(0, 8'h5A);
        check(byte_valid && byte_ext && byte_data == 8'h5A && !ext_req, "R6 delivery", byte_data, 8'h5A);

        // R5: strap low sends the low region outside
        low_rom_en = 1'b0;
        load_en = 1'b1; load_addr = 16'h0010;
        @(negedge clk);
        load_en = 1'b0; fetch_req = 1'b1;
        @(negedge clk);
        fetch_req = 1'b0;
        check(ext_req && ext_addr == 16'h0010, "R5 strap low external", ext_req, 1);
        serve_ext(3, 8'hE7);
        check(byte_ext && byte_data == 8'hE7, "R5 external byte", byte_data, 8'hE7);

        // R3: wrap at the top of the space
        low_rom_en = 1'b1;
        load_en = 1'b1; load_addr = 16'hFFFF;
        @(negedge clk);
        load_en = 1'b0; fetch_req = 1'b1;
        @(negedge clk);
        fetch_req = 1'b0;
        serve_ext(1, 8'h3C);
        check(pc == 16'h0000, "R3 wrap", pc, 16'h0000);

        // R8: stray ext_valid while idle
        ext_valid = 1'b1; ext_data = 8'hFF;
        repeat (2) @(negedge clk);
        ext_valid = 1'b0;
        check(!byte_valid && pc == 16'h0000, "R8 stray valid", {byte_valid, pc}, 0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            fetch_req  = ($urandom % 4) != 0;
            load_en    = ($urandom % 12) == 0;
            load_addr  = ($urandom % 2) ? 16'(16'h0FF0 + ($urandom % 32)) : 16'($urandom);
            if (($urandom % 64) == 0) low_rom_en = ~low_rom_en;
            ext_valid  = ($urandom % 3) == 0;
            ext_data   = 8'($urandom);
            @(negedge clk);
        end
        fetch_req = 1'b0; load_en = 1'b0; ext_valid = 1'b0;
        @(negedge clk);
        summary();
    end
endmodule